// File: doc/BRIEF.md
# Master-Clock Frequency Error PI Controller

This block closes a software-style frequency-locking loop in hardware. A free-running 16-bit counter, outside the block, counts edges of the local audio master clock. Once per measurement interval (10 ms) the counter value is presented together with a one-cycle strobe. The controller does three things with each new sample:

- It takes the wrapped count difference since the previous sample.
- It compares that difference with the residue expected for the selected nominal rate, giving a signed error that is negative when the clock runs fast.
- It accumulates the error into a saturating integral term.

The output is a fractional setting for a downstream modulator. It equals the nominal starting setting for the selected rate plus a proportional-integral correction. The integral gain is 32 and the proportional gain is zero unless overridden. The gain products are scaled down by an arithmetic right shift.

The first sample after reset only seeds the previous-count register, because no interval can be measured yet. Each later sample produces exactly one updated setting, marked by a one-cycle valid pulse. The setting holds its value between updates.

Top module: `clk_err_pi`

## Requirements
- R1: While `rst` is high and after it falls, `setting_valid` is 0 and `setting` is 0 until the first correction is produced. The integral term starts at 0.
- R2: The first strobed sample after reset is only recorded. It produces no `setting_valid` pulse and leaves `setting` unchanged.
- R3: For each later sample, `dev` is (count − previous count − expected) mod 2^16, read as a signed 16-bit value. The error is −dev. Expected is 29184 when `rate_sel` = 0 (22.5792 MHz) and 49152 when `rate_sel` = 1 (24.576 MHz).
- R4: The counter wraps, so a sample below the previous one yields the same error as the unwrapped difference would.
- R5: The integral term adds the error once per correction and saturates at the signed ACC_W-bit limits instead of wrapping. It is unchanged when no correction happens.
- R6: `setting` = INIT(rate) + ((KP·error + KI·integral) >>> SHIFT), truncated to OUT_W bits in two's complement. The integral term is the value after the current update. INIT is 555326 for `rate_sel` = 0 and 553648 for `rate_sel` = 1. Defaults are KP = 0, KI = 32, SHIFT = 5.
- R7: Suppose a strobe is captured on clock edge k. Then `setting_valid` is high for exactly the cycle after edge k+2, and `setting` changes only on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | Nominal rate: 0 = 22.5792 MHz, 1 = 24.576 MHz |
| smp_valid | input | 1 | One-cycle strobe marking a new counter sample |
| smp_count | input | 16 | Free-running master-clock edge count |
| setting | output | OUT_W | Fractional setting for the modulator |
| setting_valid | output | 1 | One-cycle pulse when `setting` has been updated |

## Verification
The bench builds the block with ACC_W = 20 and KP = 4. The narrow accumulator brings both saturation limits within reach in about twenty maximum-size errors. The nonzero proportional gain makes the current error visible in the output alongside the integral term. Directed cases cover counter wrap, the −32768 deviation corner, switching rates, and re-arming the first-sample rule by a mid-run reset. Random residues around both nominal rates fill out the rest.

// File: rtl/clk_err_pkg.sv
package clk_err_pkg;
  localparam int CNT_W  = 16;
  localparam int ERR_W  = CNT_W + 1;
  localparam int GAIN_W = 16;

  typedef enum logic {
    RATE_44K1 = 1'b0,
    RATE_48K  = 1'b1
  } rate_e;
endpackage

// File: rtl/clk_err_meas.sv
module clk_err_meas
  import clk_err_pkg::*;
#(
  parameter int EXP_44 = 29184,
  parameter int EXP_48 = 49152
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rate_sel,
  input  logic                    smp_valid,
  input  logic [CNT_W-1:0]        smp_count,
  output logic                    upd_o,
  output logic signed [ERR_W-1:0] err_o,
  output rate_e                   rate_o
);
  localparam logic [CNT_W-1:0] EXP_A = CNT_W'(EXP_44);
  localparam logic [CNT_W-1:0] EXP_B = CNT_W'(EXP_48);

  logic             first_q;
  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] exp_sel;
  logic [CNT_W-1:0] dev;
  logic signed [ERR_W-1:0] dev_x;

  always_comb begin
    exp_sel = (rate_e'(rate_sel) == RATE_48K) ? EXP_B : EXP_A;
    dev     = smp_count - prev_q - exp_sel;
    dev_x   = {dev[CNT_W-1], dev};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b1;
      prev_q  <= '0;
      upd_o   <= 1'b0;
      err_o   <= '0;
      rate_o  <= RATE_44K1;
    end else begin
      upd_o <= 1'b0;
      if (smp_valid) begin
        prev_q  <= smp_count;
        first_q <= 1'b0;
        if (!first_q) begin
          upd_o  <= 1'b1;
          err_o  <= -dev_x;
          rate_o <= rate_e'(rate_sel);
        end
      end
    end
  end

  assert_first_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (first_q && smp_valid) |=> !upd_o);
  assert_later_update_R2: assert property (@(posedge clk) disable iff (rst)
    (!first_q && smp_valid) |=> upd_o);
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !upd_o);
endmodule

// File: rtl/clk_err_integ.sv
module clk_err_integ
  import clk_err_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  rate_e                   rate_i,
  output logic                    upd_o,
  output logic signed [ERR_W-1:0] err_o,
  output rate_e                   rate_o,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W:0]   sum;
  logic signed [ACC_W-1:0] acc_nx;

  always_comb begin
    sum = {acc_o[ACC_W-1], acc_o} + {{(ACC_W+1-ERR_W){err_i[ERR_W-1]}}, err_i};
    if (sum[ACC_W] != sum[ACC_W-1])
      acc_nx = sum[ACC_W] ? ACC_MIN : ACC_MAX;
    else
      acc_nx = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o  <= '0;
      upd_o  <= 1'b0;
      err_o  <= '0;
      rate_o <= RATE_44K1;
    end else begin
      upd_o <= upd_i;
      if (upd_i) begin
        acc_o  <= acc_nx;
        err_o  <= err_i;
        rate_o <= rate_i;
      end
    end
  end

  assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(acc_o));
  assert_acc_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_i && err_i >= 0) |=> (acc_o >= $past(acc_o)));
  assert_acc_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_i && err_i <= 0) |=> (acc_o <= $past(acc_o)));
endmodule

// File: rtl/clk_err_out.sv
module clk_err_out
  import clk_err_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int OUT_W   = 32,
  parameter int KP      = 0,
  parameter int KI      = 32,
  parameter int SHIFT   = 5,
  parameter int INIT_44 = 555326,
  parameter int INIT_48 = 553648
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    upd_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  rate_e                   rate_i,
  input  logic signed [ACC_W-1:0] acc_i,
  output logic [OUT_W-1:0]        setting,
  output logic                    setting_valid
);
  localparam int SUM_W = ACC_W + GAIN_W + 2;
  localparam logic signed [SUM_W-1:0] KP_W = SUM_W'(KP);
  localparam logic signed [SUM_W-1:0] KI_W = SUM_W'(KI);
  localparam logic signed [SUM_W-1:0] IA_W = SUM_W'(INIT_44);
  localparam logic signed [SUM_W-1:0] IB_W = SUM_W'(INIT_48);

  logic signed [SUM_W-1:0] err_x, acc_x, pi_raw, pi_scl, total;

  always_comb begin
    err_x  = {{(SUM_W-ERR_W){err_i[ERR_W-1]}}, err_i};
    acc_x  = {{(SUM_W-ACC_W){acc_i[ACC_W-1]}}, acc_i};
    pi_raw = KP_W * err_x + KI_W * acc_x;
    pi_scl = pi_raw >>> SHIFT;
    total  = ((rate_i == RATE_48K) ? IB_W : IA_W) + pi_scl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setting       <= '0;
      setting_valid <= 1'b0;
    end else begin
      setting_valid <= upd_i;
      if (upd_i) setting <= total[OUT_W-1:0];
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (rst)
    upd_i |=> setting_valid);
  assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> !setting_valid);
  assert_setting_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> $stable(setting));
endmodule

// File: rtl/clk_err_pi.sv
module clk_err_pi
  import clk_err_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int OUT_W   = 32,
  parameter int KP      = 0,
  parameter int KI      = 32,
  parameter int SHIFT   = 5,
  parameter int EXP_44  = 29184,
  parameter int EXP_48  = 49152,
  parameter int INIT_44 = 555326,
  parameter int INIT_48 = 553648
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_sel,
  input  logic             smp_valid,
  input  logic [15:0]      smp_count,
  output logic [OUT_W-1:0] setting,
  output logic             setting_valid
);
  logic                    m_upd, i_upd;
  logic signed [ERR_W-1:0] m_err, i_err;
  rate_e                   m_rate, i_rate;
  logic signed [ACC_W-1:0] acc;

  clk_err_meas #(.EXP_44(EXP_44), .EXP_48(EXP_48)) u_meas (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .smp_valid(smp_valid),
    .smp_count(smp_count), .upd_o(m_upd), .err_o(m_err), .rate_o(m_rate)
  );

  clk_err_integ #(.ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .upd_i(m_upd), .err_i(m_err), .rate_i(m_rate),
    .upd_o(i_upd), .err_o(i_err), .rate_o(i_rate), .acc_o(acc)
  );

  clk_err_out #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .KP(KP), .KI(KI), .SHIFT(SHIFT),
    .INIT_44(INIT_44), .INIT_48(INIT_48)
  ) u_out (
    .clk(clk), .rst(rst), .upd_i(i_upd), .err_i(i_err), .rate_i(i_rate),
    .acc_i(acc), .setting(setting), .setting_valid(setting_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!setting_valid && setting == '0));
endmodule

// File: tb/clk_err_pi_bench.sv
`timescale 1ns/1ps
module clk_err_pi_bench;
  localparam int ACC_W = 20;
  localparam int OUT_W = 32;
  localparam int KP = 4, KI = 32, SHIFT = 5;

  logic clk = 1'b0, rst = 1'b1, rate_sel = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_count = '0;
  logic [OUT_W-1:0] setting;
  logic setting_valid;

  int checks = 0, errors = 0;
  bit m_first = 1;
  logic [15:0] m_prev = '0;
  longint m_acc = 0;
  logic [OUT_W-1:0] m_set = '0;

  always #4 clk = ~clk;

  clk_err_pi #(.ACC_W(ACC_W), .OUT_W(OUT_W), .KP(KP), .KI(KI), .SHIFT(SHIFT)) u_clk_err_pi (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .smp_valid(smp_valid),
    .smp_count(smp_count), .setting(setting), .setting_valid(setting_valid)
  );

  function automatic int exp_res(input logic r);
    return r ? 49152 : 29184;
  endfunction
  function automatic longint init_of(input logic r);
    return r ? 64'sd553648 : 64'sd555326;
  endfunction
  function automatic longint err_of(input logic [15:0] c, input logic [15:0] p, input logic r);
    logic [15:0] d;
    longint v;
    d = c - p - 16'(exp_res(r));
    v = longint'(d);
    if (v >= 32768) v = v - 65536;
    return -v;
  endfunction
  function automatic longint sat_acc(input longint a);
    longint mx, mn;
    mx = (64'sd1 <<< (ACC_W-1)) - 1;
    mn = -(64'sd1 <<< (ACC_W-1));
    if (a > mx) return mx;
    if (a < mn) return mn;
    return a;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // drive one sample and check the result three edges later
  task automatic send(input logic [15:0] c, input logic r, input string tag);
    longint e, s;
    @(negedge clk);
    smp_count = c; rate_sel = r; smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (m_first) begin
      chk(setting_valid == 1'b0, {"R2 first sample silent ", tag}, longint'(setting_valid), 0);
      chk(setting == m_set, {"R2 first sample keeps setting ", tag}, longint'(setting), longint'(m_set));
      m_first = 0;
    end else begin
      e = err_of(c, m_prev, r);
      m_acc = sat_acc(m_acc + e);
      s = init_of(r) + ((KP * e + KI * m_acc) >>> SHIFT);
      m_set = s[OUT_W-1:0];
      chk(setting_valid == 1'b1, {"R7 valid pulse ", tag}, longint'(setting_valid), 1);
      chk(setting == m_set, {"R6 R3 setting ", tag}, longint'(setting), longint'(m_set));
    end
    m_prev = c;
    @(negedge clk);
    chk(setting_valid == 1'b0, {"R7 pulse one cycle ", tag}, longint'(setting_valid), 0);
    chk(setting == m_set, {"R7 setting held ", tag}, longint'(setting), longint'(m_set));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(setting_valid == 1'b0, "R1 valid low in reset", longint'(setting_valid), 0);
    chk(setting == '0, "R1 setting zero in reset", longint'(setting), 0);
    rst = 1'b0;
    m_first = 1; m_acc = 0; m_set = '0;
    repeat (2) @(negedge clk);
    chk(setting == '0 && setting_valid == 1'b0, "R1 idle after reset", longint'(setting), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] cur;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    do_reset();
    cur = 16'd1000;
    send(cur, 1'b0, "seed");                     // R2
    cur = cur + 16'd29184;
    send(cur, 1'b0, "exact rate0");              // R3 err 0 -> init
    cur = cur + 16'd29284;
    send(cur, 1'b0, "fast by 100");              // R3 negative error
    cur = cur + 16'd29000;
    send(cur, 1'b0, "slow by 184");
    cur = 16'd65500;
    send(cur, 1'b0, "near top");
    cur = cur + 16'd29184 + 16'd7;               // wraps below previous: R4
    send(cur, 1'b0, "wrap R4");
    cur = cur + 16'd49152;
    send(cur, 1'b1, "exact rate1");              // R3 rate1
    cur = cur + 16'd49152 + 16'd32768;
    send(cur, 1'b1, "dev -32768 corner");        // err +32768
    for (int i = 0; i < 22; i++) begin           // drive to upper limit: R5
      cur = cur + 16'd29184 - 16'd30000;
      send(cur, 1'b0, "sat high R5");
    end
    chk(m_acc == (64'sd1 <<< (ACC_W-1)) - 1, "R5 model at upper limit", m_acc, (64'sd1 <<< (ACC_W-1)) - 1);
    for (int i = 0; i < 40; i++) begin           // drive to lower limit: R5
      cur = cur + 16'd49152 + 16'd30000;
      send(cur, 1'b1, "sat low R5");
    end
    for (int i = 0; i < 200; i++) begin
      logic r;
      int jit;
      r = 1'($urandom_range(1, 0));
      jit = int'($urandom_range(4000, 0)) - 2000;
      cur = cur + 16'(exp_res(r)) + 16'(jit);
      send(cur, r, "random");
    end
    do_reset();                                  // R1, R2 re-armed
    cur = 16'd12345;
    send(cur, 1'b1, "reseed after reset");
    cur = cur + 16'd49152 + 16'd50;
    send(cur, 1'b1, "post reset update");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule